// File: doc/BRIEF.md
# Debug Register Access Sequencer

This block sits between a host that wants to read or write 32-bit registers on a debug target and a serial word exchanger that moves one 16-bit word at a time over a background-debug link. For each host request it issues the words that make up the command frame. It gathers any response words and returns one response carrying data and a fault code.

Two register classes use two different framings. A control-class access sends a three-word header: an opcode, a zero word, then the register code. A write follows the header with the data; a read follows it with two fetches. A debug-class access packs the opcode and the register index into one word. Debug registers other than the control/status register (CSR) cannot be read back over the link. The block therefore keeps local shadow copies and answers reads of them without link traffic. A CSR read that reports a halt while the target is thought to be running is only believed after two program-counter reads succeed over the link.

Top module: `dbg_reg_seq`

## Requirements
- R1: A control-class read (req_class=0, req_write=0) sends 0x2980, 0x0000 and the register code, then fetches two words. The first fetched word becomes data bits 31:16.
- R2: A control-class write sends five words: 0x2880, 0x0000, the register code, data bits 31:16, then data bits 15:0.
- R3: A debug-class access (req_class=1) to a mapped index sends one word. That word is the index ORed with 0x2C80 for a write or with 0x2D80 for a read. A write then sends the upper and then the lower data half. A read fetches two words, upper half first.
- R4: A read of a mapped debug index other than the CSR (index 0) returns the shadow copy and uses no link traffic. Every write to such an index updates the shadow and is also sent on the link.
- R5: After reset every shadow reads zero, except debug index 6, which reads 0x00000005.
- R6: A debug code is mapped only if code bits 11:4 are zero and bits 3:0 are one of 0, 6, 7, 8, 9, 12, 13, 14 or 15. An unmapped code reads as zero, a write to it is dropped, and neither uses the link.
- R7: Suppose a CSR read returns any of bits 27:24 set while the target is marked running. The block then makes two control reads of code 0x80F. Only if both succeed is the target marked halted and the value returned. If either read faults, bits 27:24 are cleared in the returned value, the fault code is 0, and the target stays marked running.
- R8: While the target is marked halted, a CSR read returns the fetched value ORed with the bits 27:24 captured at the halt. A control read of code 0x80E returns only its low 16 bits.
- R9: A nonzero link fault ends the request at once. No further word is sent, the fault code is returned on rsp_fault, and req_ready is high in the same cycle as rsp_valid.
- R10: A request answered locally gets rsp_valid in the cycle right after acceptance. Only one link word is outstanding at a time, so a request with n link words responds 2n cycles after acceptance when the link answers one cycle after each word.
- R11: A debug write to the CSR marks the target running again and clears the captured bits 27:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_class | input | 1 | 0 = control class, 1 = debug class |
| req_code | input | 12 | Register code |
| req_data | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Read data (zero for writes) |
| rsp_fault | output | 3 | 0 = success, else link fault code |
| lnk_req_valid | output | 1 | Word request to the exchanger |
| lnk_req_ready | input | 1 | Exchanger accepts the word |
| lnk_req_word | output | 16 | Word to send (zero on a fetch) |
| lnk_req_fetch | output | 1 | Request is a fetch of a response word |
| lnk_rsp_valid | input | 1 | Exchanger completed the word |
| lnk_rsp_word | input | 16 | Word returned by the target |
| lnk_rsp_fault | input | 3 | Nonzero when the exchange failed |

## Verification
A locally answered request is due in the cycle right after its acceptance edge. A request that uses the link is due two cycles per link word after acceptance, because the link model answers each word one cycle after it is issued. The bench notes the cycle of acceptance and the cycle of each response. It compares the gap against twice the number of link words the scoreboard expected for that request, so the bench derives a late, early or extra word from its own count. Every link word is compared in the order it appears against the expected frame, and outputs are sampled on the falling edge.

// File: rtl/dbg_reg_seq_pkg.sv
package dbg_reg_seq_pkg;
    localparam int CODE_W   = 12;
    localparam int FAULT_W  = 3;
    localparam int WORD_W   = 16;
    localparam int DATA_W   = 2 * WORD_W;
    localparam int MAX_SEND = 5;
    localparam int IDX_W    = $clog2(MAX_SEND + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [IDX_W-1:0]    idx;
        logic [1:0]          pass;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   csr_val;
        logic                wr;
        logic                cls;
        logic [CODE_W-1:0]   code;
        logic [DATA_W-1:0]   wdata;
        logic                running;
        logic [3:0]          halt_bits;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rsp_data;
        logic [FAULT_W-1:0]  rsp_fault;
    } seq_t;
endpackage

// File: rtl/dbg_reg_seq_frame.sv
module dbg_reg_seq_frame
    import dbg_reg_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] RD_CTL_OP = 16'h2980,
    parameter logic [WORD_W-1:0] WR_CTL_OP = 16'h2880,
    parameter logic [WORD_W-1:0] RD_DBG_OP = 16'h2D80,
    parameter logic [WORD_W-1:0] WR_DBG_OP = 16'h2C80,
    parameter logic [CODE_W-1:0] PC_CODE   = 12'h80F
) (
    input  logic                             is_wr,
    input  logic                             is_dbg,
    input  logic                             pc_mode,
    input  logic [CODE_W-1:0]                code,
    input  logic [DATA_W-1:0]                data,
    output logic [MAX_SEND-1:0][WORD_W-1:0]  words,
    output logic [IDX_W-1:0]                 n_send,
    output logic [IDX_W-1:0]                 n_total
);
    always_comb begin
        words   = '0;
        n_send  = IDX_W'(3);
        n_total = IDX_W'(5);
        if (pc_mode) begin
            words[0] = RD_CTL_OP;
            words[2] = WORD_W'(PC_CODE);
        end else if (!is_dbg) begin
            words[0] = is_wr ? WR_CTL_OP : RD_CTL_OP;
            words[2] = WORD_W'(code);
            if (is_wr) begin
                words[3] = data[DATA_W-1:WORD_W];
                words[4] = data[WORD_W-1:0];
                n_send   = IDX_W'(5);
            end
        end else begin
            words[0] = (is_wr ? WR_DBG_OP : RD_DBG_OP) | WORD_W'(code);
            n_total  = IDX_W'(3);
            if (is_wr) begin
                words[1] = data[DATA_W-1:WORD_W];
                words[2] = data[WORD_W-1:0];
            end else begin
                n_send = IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/dbg_reg_seq_shadow.sv
module dbg_reg_seq_shadow
    import dbg_reg_seq_pkg::*;
#(
    parameter int                N_REGS    = 16,
    parameter int                ATTR_IDX  = 6,
    parameter logic [DATA_W-1:0] ATTR_INIT = 32'h0000_0005,
    localparam int               AW        = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [N_REGS-1:0][DATA_W-1:0] mem_q;

    for (genvar g = 0; g < N_REGS; g++) begin : g_ent
        localparam logic [DATA_W-1:0] INIT = (g == ATTR_IDX) ? ATTR_INIT : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mem_q[g] <= INIT;
            else if (we && addr == AW'(g))     mem_q[g] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/dbg_reg_seq.sv
module dbg_reg_seq
    import dbg_reg_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] RD_CTL_OP = 16'h2980,
    parameter logic [WORD_W-1:0] WR_CTL_OP = 16'h2880,
    parameter logic [WORD_W-1:0] RD_DBG_OP = 16'h2D80,
    parameter logic [WORD_W-1:0] WR_DBG_OP = 16'h2C80,
    parameter logic [CODE_W-1:0] PC_CODE   = 12'h80F,
    parameter logic [CODE_W-1:0] SR_CODE   = 12'h80E,
    parameter int                DBG_REGS  = 16,
    parameter logic [DBG_REGS-1:0] DBG_MAP = 16'hF3C1,
    parameter int                CSR_IDX   = 0,
    parameter int                ATTR_IDX  = 6,
    parameter logic [DATA_W-1:0] ATTR_INIT = 32'h0000_0005,
    parameter int                HALT_LSB  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_class,
    input  logic [CODE_W-1:0]  req_code,
    input  logic [DATA_W-1:0]  req_data,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [FAULT_W-1:0] rsp_fault,
    output logic               lnk_req_valid,
    input  logic               lnk_req_ready,
    output logic [WORD_W-1:0]  lnk_req_word,
    output logic               lnk_req_fetch,
    input  logic               lnk_rsp_valid,
    input  logic [WORD_W-1:0]  lnk_rsp_word,
    input  logic [FAULT_W-1:0] lnk_rsp_fault
);
    localparam int                DIW       = $clog2(DBG_REGS);
    localparam logic [DATA_W-1:0] HALT_MASK = DATA_W'(4'hF) << HALT_LSB;

    seq_t q, d;

    logic [MAX_SEND-1:0][WORD_W-1:0] words;
    logic [IDX_W-1:0]  n_send, n_total;
    logic              fetch_step, shadow_we;
    logic [DATA_W-1:0] shadow_rd, acc_next, fin_acc;
    logic              req_mapped, req_is_csr, q_is_csr;

    dbg_reg_seq_frame #(
        .RD_CTL_OP(RD_CTL_OP), .WR_CTL_OP(WR_CTL_OP),
        .RD_DBG_OP(RD_DBG_OP), .WR_DBG_OP(WR_DBG_OP), .PC_CODE(PC_CODE)
    ) i_frame (
        .is_wr(q.wr), .is_dbg(q.cls), .pc_mode(q.pass != 2'd0),
        .code(q.code), .data(q.wdata),
        .words(words), .n_send(n_send), .n_total(n_total)
    );

    dbg_reg_seq_shadow #(
        .N_REGS(DBG_REGS), .ATTR_IDX(ATTR_IDX), .ATTR_INIT(ATTR_INIT)
    ) i_shadow (
        .clk(clk), .rst_n(rst_n), .we(shadow_we),
        .addr(req_code[DIW-1:0]), .wdata(req_data), .rdata(shadow_rd)
    );

    assign req_mapped = (req_code[CODE_W-1:DIW] == '0) && DBG_MAP[req_code[DIW-1:0]];
    assign req_is_csr = (req_code == CODE_W'(CSR_IDX));
    assign q_is_csr   = q.cls && (q.code == CODE_W'(CSR_IDX));
    assign fetch_step = (q.idx >= n_send);
    assign acc_next   = {q.acc[WORD_W-1:0], lnk_rsp_word};
    assign fin_acc    = fetch_step ? acc_next : q.acc;

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        shadow_we   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr    = req_write;
                    d.cls   = req_class;
                    d.code  = req_code;
                    d.wdata = req_data;
                    d.idx   = '0;
                    d.pass  = 2'd0;
                    d.acc   = '0;
                    d.rsp_data  = '0;
                    d.rsp_fault = '0;
                    if (!req_class) begin
                        d.st = ST_ISSUE;
                    end else if (!req_mapped) begin
                        d.rsp_valid = 1'b1;
                    end else if (!req_is_csr) begin
                        shadow_we = req_write;
                        if (req_write) begin
                            d.st = ST_ISSUE;
                        end else begin
                            d.rsp_valid = 1'b1;
                            d.rsp_data  = shadow_rd;
                        end
                    end else begin
                        if (req_write) begin
                            d.running   = 1'b1;
                            d.halt_bits = '0;
                        end
                        d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (lnk_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (lnk_rsp_valid) begin
                    if (lnk_rsp_fault != '0) begin
                        d.st        = ST_IDLE;
                        d.rsp_valid = 1'b1;
                        if (q.pass == 2'd0) begin
                            d.rsp_data  = '0;
                            d.rsp_fault = lnk_rsp_fault;
                        end else begin
                            d.rsp_data  = q.csr_val & ~HALT_MASK;
                            d.rsp_fault = '0;
                        end
                    end else if (q.idx != n_total - IDX_W'(1)) begin
                        d.acc = fin_acc;
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = ST_ISSUE;
                    end else begin
                        d.idx = '0;
                        d.acc = '0;
                        unique case (q.pass)
                            2'd0: begin
                                if (!q.wr && q_is_csr && q.running &&
                                    ((fin_acc & HALT_MASK) != '0)) begin
                                    d.csr_val = fin_acc;
                                    d.pass    = 2'd1;
                                    d.st      = ST_ISSUE;
                                end else begin
                                    d.st        = ST_IDLE;
                                    d.rsp_valid = 1'b1;
                                    if (q.wr)
                                        d.rsp_data = '0;
                                    else if (!q.cls && q.code == SR_CODE)
                                        d.rsp_data = {{WORD_W{1'b0}}, fin_acc[WORD_W-1:0]};
                                    else if (q.cls && !q.running)
                                        d.rsp_data = fin_acc | (DATA_W'(q.halt_bits) << HALT_LSB);
                                    else
                                        d.rsp_data = fin_acc;
                                end
                            end
                            2'd1: begin
                                d.pass = 2'd2;
                                d.st   = ST_ISSUE;
                            end
                            default: begin
                                d.running   = 1'b0;
                                d.halt_bits = q.csr_val[HALT_LSB +: 4];
                                d.rsp_valid = 1'b1;
                                d.rsp_data  = q.csr_val;
                                d.st        = ST_IDLE;
                            end
                        endcase
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.running <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_valid     = q.rsp_valid;
    assign rsp_data      = q.rsp_data;
    assign rsp_fault     = q.rsp_fault;
    assign lnk_req_valid = (q.st == ST_ISSUE);
    assign lnk_req_fetch = fetch_step;
    assign lnk_req_word  = fetch_step ? '0 : words[q.idx];
endmodule

// File: rtl/dbg_reg_seq_chk.sv
module dbg_reg_seq_chk
    import dbg_reg_seq_pkg::*;
#(
    parameter int              DBG_REGS = 16,
    parameter logic [15:0]     DBG_MAP  = 16'hF3C1,
    localparam int             DIW      = $clog2(DBG_REGS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_write,
    input logic               req_class,
    input logic [CODE_W-1:0]  req_code,
    input logic               rsp_valid,
    input logic [FAULT_W-1:0] rsp_fault,
    input logic               lnk_req_valid,
    input logic               lnk_req_ready,
    input logic [WORD_W-1:0]  lnk_req_word
);
    logic acc_hit, mapped;
    assign acc_hit = req_valid && req_ready && req_class;
    assign mapped  = (req_code[CODE_W-1:DIW] == '0) && DBG_MAP[req_code[DIW-1:0]];

    // R4: shadow read answered next cycle, with no link word
    a_r4_shadow_local: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit && !req_write && mapped && (req_code != '0) |=> rsp_valid && !lnk_req_valid);

    // R6: unmapped code answered locally
    a_r6_unmapped_local: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit && !mapped |=> rsp_valid && !lnk_req_valid);

    // R9: response (fault or not) coincides with ready
    a_r9_ready_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R9: a faulted request sends nothing more
    a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != '0) |-> !lnk_req_valid);

    // R10: one link word outstanding
    a_r10_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid && lnk_req_ready |=> !lnk_req_valid);

    // R10: stalled word held steady
    a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid && !lnk_req_ready |=> lnk_req_valid && $stable(lnk_req_word));
endmodule

bind dbg_reg_seq dbg_reg_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_class(req_class), .req_code(req_code),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .lnk_req_valid(lnk_req_valid),
    .lnk_req_ready(lnk_req_ready), .lnk_req_word(lnk_req_word)
);

// File: tb/test_dbg_reg_seq.sv
`timescale 1ns/1ps
module test_dbg_reg_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_class = 1'b0;
    logic [11:0] req_code = '0;
    logic [31:0] req_data = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic [2:0]  rsp_fault;
    logic        lnk_req_valid, lnk_req_fetch;
    logic        lnk_req_ready = 1'b1;
    logic [15:0] lnk_req_word;
    logic        lnk_rsp_valid = 1'b0;
    logic [15:0] lnk_rsp_word = '0;
    logic [2:0]  lnk_rsp_fault = '0;

    always #4 clk = ~clk;

    dbg_reg_seq i_dbg_reg_seq (.*);

    int n_chk = 0, n_err = 0, cyc = 0, link_cnt = 0, fault_at = -1;
    int rsp_cnt = 0, rsp_cyc = 0;
    bit done = 0;
    string cur_tag = "R0";
    logic [16:0] exp_lnk[$];
    logic [15:0] fetch_q[$];
    logic [34:0] exp_rsp[$];

    task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // link model: answers each word one cycle after it is issued
    initial begin
        bit pend = 0, pend_fetch = 0;
        forever begin
            @(negedge clk);
            lnk_rsp_valid = 1'b0;
            lnk_rsp_fault = '0;
            lnk_rsp_word  = '0;
            if (pend) begin
                lnk_rsp_valid = 1'b1;
                if (pend_fetch && fetch_q.size() > 0) lnk_rsp_word = fetch_q.pop_front();
                if (link_cnt - 1 == fault_at) lnk_rsp_fault = 3'd5;
                pend = 0;
            end else if (lnk_req_valid) begin
                if (exp_lnk.size() == 0)
                    chk({cur_tag, " extra link word"}, {18'd0, lnk_req_fetch, lnk_req_word}, 35'h7_FFFF_FFFF);
                else
                    chk({cur_tag, " link word"}, {18'd0, lnk_req_fetch, lnk_req_word},
                        {18'd0, exp_lnk.pop_front()});
                link_cnt++;
                pend = 1;
                pend_fetch = lnk_req_fetch;
            end
        end
    end

    // response monitor (scoreboard pop)
    initial forever begin
        @(negedge clk);
        if (rsp_valid) begin
            chk("R9 ready with response", {34'd0, req_ready}, 35'd1);
            if (exp_rsp.size() == 0)
                chk({cur_tag, " unexpected response"}, {rsp_fault, rsp_data}, 35'h7_FFFF_FFFF);
            else
                chk({cur_tag, " response"}, {rsp_fault, rsp_data}, exp_rsp.pop_front());
            rsp_cyc = cyc;
            rsp_cnt++;
        end
    end

    task automatic send(input logic [15:0] w);  exp_lnk.push_back({1'b0, w}); endtask
    task automatic fetch(input logic [15:0] w); exp_lnk.push_back({1'b1, 16'h0}); fetch_q.push_back(w); endtask
    task automatic pc_read(input logic [15:0] hi, input logic [15:0] lo);
        send(16'h2980); send(16'h0000); send(16'h080F); fetch(hi); fetch(lo);
    endtask

    task automatic xact(input string tag, input logic w, input logic c, input logic [11:0] code,
                        input logic [31:0] data, input logic [2:0] efault, input logic [31:0] edata);
        int n0, acc_cyc, lat;
        cur_tag = tag;
        lat = 2 * exp_lnk.size();
        exp_rsp.push_back({efault, edata});
        n0 = rsp_cnt;
        @(negedge clk);
        chk({tag, " ready before request"}, {34'd0, req_ready}, 35'd1);
        req_valid = 1'b1; req_write = w; req_class = c; req_code = code; req_data = data;
        acc_cyc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_cnt == n0) @(negedge clk);
        chk({tag, " R10 latency"}, 35'(rsp_cyc - acc_cyc), 35'(lat));
        chk({tag, " link frame complete"}, 35'(exp_lnk.size()), 35'd0);
        exp_lnk.delete();
        fetch_q.delete();
        fault_at = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset req_ready", {34'd0, req_ready}, 35'd1);
        chk("reset rsp_valid", {34'd0, rsp_valid}, 35'd0);
        chk("reset lnk_req_valid", {34'd0, lnk_req_valid}, 35'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 control write
        send(16'h2880); send(16'h0000); send(16'h0002); send(16'h1234); send(16'h5678);
        xact("R2", 1, 0, 12'h002, 32'h1234_5678, 0, 32'h0);
        // R1 control read, upper half first
        send(16'h2980); send(16'h0000); send(16'h0801); fetch(16'hAAAA); fetch(16'h5555);
        xact("R1", 0, 0, 12'h801, 0, 0, 32'hAAAA_5555);
        // R8 status register low half
        send(16'h2980); send(16'h0000); send(16'h080E); fetch(16'hFFFF); fetch(16'h2704);
        xact("R8 sr", 0, 0, 12'h80E, 0, 0, 32'h0000_2704);
        // R5 initial shadows
        xact("R5 attr", 0, 1, 12'h006, 0, 0, 32'h0000_0005);
        xact("R5 zero", 0, 1, 12'h007, 0, 0, 32'h0);
        // R3 debug write, R4 shadow update
        send(16'h2C87); send(16'hDEAD); send(16'hBEEF);
        xact("R3 wr", 1, 1, 12'h007, 32'hDEAD_BEEF, 0, 32'h0);
        xact("R4 shadow", 0, 1, 12'h007, 0, 0, 32'hDEAD_BEEF);
        // R6 unmapped codes
        xact("R6 wr", 1, 1, 12'h001, 32'h1111_1111, 0, 32'h0);
        xact("R6 rd", 0, 1, 12'h001, 0, 0, 32'h0);
        xact("R6 hi", 0, 1, 12'h016, 0, 0, 32'h0);
        // R3 CSR read while running, no halt bits
        send(16'h2D80); fetch(16'h0010); fetch(16'h0000);
        xact("R3 rd", 0, 1, 12'h000, 0, 0, 32'h0010_0000);
        // R7 confirmed halt
        send(16'h2D80); fetch(16'h0100); fetch(16'h0000);
        pc_read(16'h0000, 16'h4000); pc_read(16'h0000, 16'h4000);
        xact("R7 halt", 0, 1, 12'h000, 0, 0, 32'h0100_0000);
        // R8 halted: OR captured bits, no PC reads
        send(16'h2D80); fetch(16'h0000); fetch(16'h0001);
        xact("R8 or", 0, 1, 12'h000, 0, 0, 32'h0100_0001);
        // R11 CSR write rearms running
        send(16'h2C80); send(16'h0000); send(16'h0000);
        xact("R11 wr", 1, 1, 12'h000, 0, 0, 32'h0);
        send(16'h2D80); fetch(16'h0000); fetch(16'h0002);
        xact("R11 running", 0, 1, 12'h000, 0, 0, 32'h0000_0002);
        // R7 second PC read faults: bits cleared, still running
        send(16'h2D80); fetch(16'h0200); fetch(16'h0000);
        pc_read(16'h0, 16'h0); send(16'h2980);
        fault_at = link_cnt + 8;
        xact("R7 reject", 0, 1, 12'h000, 0, 0, 32'h0);
        send(16'h2D80); fetch(16'h0300); fetch(16'h0000);
        pc_read(16'h0, 16'h0); pc_read(16'h0, 16'h0);
        xact("R7 kept running", 0, 1, 12'h000, 0, 0, 32'h0300_0000);
        // R9 fault on second word of a control write
        send(16'h2880); send(16'h0000);
        fault_at = link_cnt + 1;
        xact("R9 fault", 1, 0, 12'h004, 32'h0BAD_F00D, 3'd5, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule